// File: doc/BRIEF.md
# Dual-Mode Buzzer Tone Generator

This block drives one buzzer pin from either of two sources. In overflow-toggle mode the pin level inverts every time the chosen timer reports an overflow, so the tone pitch is set by the timer period. In divided-clock mode the pin carries a 50% duty square wave obtained by dividing the system clock by 2, 4, 8 or 16. A gate bit switches the wave on and off.

A 4-bit configuration word is loaded by a one-cycle write strobe. It selects the mode, the timer or ratio, and the gate. A separate pin-function enable, owned by the port logic, lets the result reach the pin. The gate acts only while the divided clock is low, so every pulse on the pin has full width. After any change of mode or ratio the divider restarts and stays silent for a hold-off window. This gives downstream logic a clean start.

Top module: `buzz_tone_gen`

## Requirements
- R1: After reset the configuration word is 0000, the pin is low and the internal toggle level is 0.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` replaces the configuration word at that edge. The new word governs behaviour from the next cycle on.
- R3: With word bit 2 = 0 (toggle mode), bit 1 = 0 selects `tmr_a_ovf` and bit 1 = 1 selects `tmr_b_ovf`. Each strobe of the selected input inverts the pin one cycle later. A strobe on the other input has no effect.
- R4: With bit 2 = 1 (divided mode), bits 1:0 = 00, 01, 10, 11 give a period of 2, 4, 8 or 16 clock cycles. The high and low halves are equal.
- R5: In divided mode, bit 3 = 0 keeps the pin low once the current high phase has ended. Bit 3 = 1 lets the pulses through.
- R6: Every high pulse on the pin in divided mode lasts exactly half the selected period, whenever bit 3 is written. The gate state changes only on edges after which the divided clock is low.
- R7: A write that changes bits 2:0 restarts the divider. The divided clock is low for the 5 cycles after that write edge, and on the next 4 edges the counter is held, before counting resumes from zero.
- R8: When `pin_en` is 0 the pin is 0. The toggle level keeps following overflow strobes, and the result shows when `pin_en` returns to 1.
- R9: A write during toggle mode leaves the toggle level unchanged. Overflow strobes during divided mode do not alter the toggle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | One-cycle write strobe for the configuration word |
| cfg_wdata | input | 4 | Configuration word: bit 3 gate, bit 2 mode, bits 1:0 source or ratio |
| pin_en | input | 1 | Pin-function enable from the port logic |
| tmr_a_ovf | input | 1 | Single-cycle overflow strobe of the first timer |
| tmr_b_ovf | input | 1 | Single-cycle overflow strobe of the second timer |
| buzz_out | output | 1 | Buzzer pin drive |

## Verification
A wrong divider count or ratio decode shows as a pulse width or period off by whole cycles. Such an error appears at the first falling edge after the hold-off. A gate that updates while the divided clock is high cuts a pulse short, and this shows in the same cycle the gate closes. A toggle level that drifts or flips on the wrong timer shows one cycle after the stray strobe. If it drifts while the pin is disabled or in divided mode, it shows as soon as the pin is enabled again in toggle mode. The bench compares the pin to a behavioural model on every cycle and measures every high pulse, so each of these faults is caught within one divided period.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  localparam int SEL_W     = 2;
  localparam int NUM_RATIO = 1 << SEL_W;
  localparam int CNT_W     = NUM_RATIO;

  typedef struct packed {
    logic             gate;
    logic             clk_mode;
    logic [SEL_W-1:0] sel;
  } buzz_cfg_t;

  // A change of mode or ratio forces a divider restart.
  function automatic logic needs_restart(buzz_cfg_t cur, buzz_cfg_t nxt);
    return (cur.clk_mode != nxt.clk_mode) || (cur.sel != nxt.sel);
  endfunction

  // Divided-clock phase: counter bit picked by the ratio select.
  function automatic logic phase_of(logic [CNT_W-1:0] cnt, logic [SEL_W-1:0] sel);
    return cnt[sel];
  endfunction

  function automatic logic ovf_pick(logic src_b, logic ovf_a, logic ovf_b);
    return src_b ? ovf_b : ovf_a;
  endfunction
endpackage

// File: rtl/buzz_cfg_reg.sv
module buzz_cfg_reg
  import buzz_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  logic [3:0] wdata,
  output buzz_cfg_t cfg,
  output logic      restart
);
  buzz_cfg_t cfg_q;
  buzz_cfg_t wr_cfg;

  assign wr_cfg  = buzz_cfg_t'(wdata);
  assign restart = we && needs_restart(cfg_q, wr_cfg);
  assign cfg     = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= wr_cfg;
  end
endmodule

// File: rtl/buzz_prescaler.sv
module buzz_prescaler
  import buzz_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             div_clk,
  output logic             div_nxt,
  output logic             hold_busy
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              div_q;

  assign hold_busy = (hold_q != '0);

  always_comb begin
    if (restart) begin
      cnt_d  = '0;
      hold_d = HOLD_W'(HOLD_CYC);
    end else if (hold_busy) begin
      cnt_d  = '0;
      hold_d = hold_q - 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      hold_d = hold_q;
    end
  end

  assign div_nxt = phase_of(cnt_d, sel);
  assign div_clk = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      div_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      div_q  <= div_nxt;
    end
  end
endmodule

// File: rtl/buzz_gate.sv
module buzz_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_req,
  input  logic div_nxt,
  output logic gate_open
);
  logic gate_q;

  // Sample the request only on edges that leave the divided clock low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gate_q <= 1'b0;
    else if (!div_nxt) gate_q <= gate_req;
  end

  assign gate_open = gate_q;
endmodule

// File: rtl/buzz_toggle.sv
module buzz_toggle
  import buzz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic src_b,
  input  logic ovf_a,
  input  logic ovf_b,
  output logic tog_lvl,
  output logic ovf_hit
);
  logic tog_q;

  assign ovf_hit = active && ovf_pick(src_b, ovf_a, ovf_b);
  assign tog_lvl = tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (ovf_hit) tog_q <= ~tog_q;
  end
endmodule

// File: rtl/buzz_tone_gen.sv
module buzz_tone_gen
  import buzz_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  input  logic       pin_en,
  input  logic       tmr_a_ovf,
  input  logic       tmr_b_ovf,
  output logic       buzz_out
);
  buzz_cfg_t  cfg;
  logic [3:0] cfg_bits;
  logic       restart;
  logic       div_clk;
  logic       div_nxt;
  logic       hold_busy;
  logic       gate_open;
  logic       tog_lvl;
  logic       ovf_hit;
  logic       tone;

  assign cfg_bits = cfg;

  buzz_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .cfg     (cfg),
    .restart (restart)
  );

  buzz_prescaler #(.HOLD_CYC(HOLD_CYC)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .sel       (cfg.sel),
    .div_clk   (div_clk),
    .div_nxt   (div_nxt),
    .hold_busy (hold_busy)
  );

  buzz_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_req  (cfg.gate),
    .div_nxt   (div_nxt),
    .gate_open (gate_open)
  );

  buzz_toggle u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (!cfg.clk_mode),
    .src_b   (cfg.sel[SEL_W-1]),
    .ovf_a   (tmr_a_ovf),
    .ovf_b   (tmr_b_ovf),
    .tog_lvl (tog_lvl),
    .ovf_hit (ovf_hit)
  );

  assign tone     = cfg.clk_mode ? (div_clk && gate_open) : tog_lvl;
  assign buzz_out = pin_en && tone;
endmodule

// File: rtl/buzz_tone_gen_chk.sv
module buzz_tone_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_en,
  input logic       buzz_out,
  input logic [3:0] cfg_bits,
  input logic       div_clk,
  input logic       gate_open,
  input logic       tog_lvl,
  input logic       ovf_hit,
  input logic       restart,
  input logic       hold_busy
);
  a_r3_strobe_flips: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> (tog_lvl != $past(tog_lvl)));

  a_r5_gate_closes: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bits[3] ##1 !div_clk |-> !gate_open);

  a_r6_gate_at_low: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open != $past(gate_open)) |-> !div_clk);

  a_r7_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !div_clk);

  a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |=> !div_clk);

  a_r8_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> !buzz_out);
endmodule

bind buzz_tone_gen buzz_tone_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_en    (pin_en),
  .buzz_out  (buzz_out),
  .cfg_bits  (cfg_bits),
  .div_clk   (div_clk),
  .gate_open (gate_open),
  .tog_lvl   (tog_lvl),
  .ovf_hit   (ovf_hit),
  .restart   (restart),
  .hold_busy (hold_busy)
);

// File: tb/buzz_tone_gen_bench.sv
`timescale 1ns/1ps
module buzz_tone_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = 4'h0;
  logic       pin_en = 1'b0;
  logic       tmr_a_ovf = 1'b0;
  logic       tmr_b_ovf = 1'b0;
  logic       buzz_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  buzz_tone_gen u_buzz_tone_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pin_en(pin_en), .tmr_a_ovf(tmr_a_ovf), .tmr_b_ovf(tmr_b_ovf),
    .buzz_out(buzz_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Behavioural reference: integer run counter, silence countdown, levels.
  bit [3:0] m_word = 4'h0;
  bit       m_lvl = 1'b0;
  int       m_run = 0;
  int       m_quiet = 0;
  bit       m_wave = 1'b0;
  bit       m_open = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 4'h0; m_lvl = 1'b0; m_run = 0; m_quiet = 0; m_wave = 1'b0; m_open = 1'b0;
    end else begin
      int half;
      bit nwave;
      half = 1 << m_word[1:0];
      if (cfg_we && (cfg_wdata[2:0] != m_word[2:0])) begin
        m_run = 0; m_quiet = 4; nwave = 1'b0;
      end else if (m_quiet > 0) begin
        m_quiet--; m_run = 0; nwave = 1'b0;
      end else begin
        m_run++; nwave = ((m_run / half) % 2) == 1;
      end
      if (!nwave) m_open = m_word[3];
      m_wave = nwave;
      if (!m_word[2] && (m_word[1] ? tmr_b_ovf : tmr_a_ovf)) m_lvl = ~m_lvl;
      if (cfg_we) m_word = cfg_wdata;
    end
  end

  // Per-cycle comparison and high-pulse width measurement.
  int hi_len = 0;
  int exp_half = 0;
  always @(negedge clk) begin
    bit exp_pin;
    exp_pin = pin_en && (m_word[2] ? (m_wave && m_open) : m_lvl);
    check(buzz_out === exp_pin, cur_req, int'(buzz_out), int'(exp_pin));
    if (buzz_out === 1'b1) hi_len++;
    else begin
      if (hi_len > 0 && exp_half > 0) check(hi_len == exp_half, "R6", hi_len, exp_half);
      hi_len = 0;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [3:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic strobe(input bit b);
    if (b) tmr_b_ovf = 1'b1; else tmr_a_ovf = 1'b1;
    cyc(1);
    tmr_a_ovf = 1'b0; tmr_b_ovf = 1'b0;
  endtask

  initial begin
    cyc(3);
    cur_req = "R1";
    check(buzz_out === 1'b0, "R1", int'(buzz_out), 0);
    rst_n = 1'b1;
    cyc(2);
    pin_en = 1'b1;
    cyc(2);
    check(buzz_out === 1'b0, "R1", int'(buzz_out), 0);

    // Toggle mode, timer A selected: B strobes ignored.
    cur_req = "R3";
    strobe(0); cyc(1);
    check(buzz_out === 1'b1, "R3", int'(buzz_out), 1);
    strobe(1); cyc(2);
    check(buzz_out === 1'b1, "R3", int'(buzz_out), 1);
    strobe(0); cyc(2); strobe(0); strobe(0); cyc(2);

    // Switch source to timer B; level must hold.
    cur_req = "R9";
    strobe(0); cyc(1);
    wr(4'b0010); cyc(2);
    check(buzz_out === 1'b1, "R9", int'(buzz_out), 1);
    cur_req = "R2";
    strobe(0); cyc(1);
    check(buzz_out === 1'b1, "R2", int'(buzz_out), 1);
    strobe(1); cyc(1);
    check(buzz_out === 1'b0, "R3", int'(buzz_out), 0);

    // Pin disabled: level keeps following strobes.
    cur_req = "R8";
    pin_en = 1'b0;
    strobe(1); cyc(2); strobe(1); strobe(1); cyc(1);
    check(buzz_out === 1'b0, "R8", int'(buzz_out), 0);
    pin_en = 1'b1; cyc(1);
    check(buzz_out === 1'b1, "R8", int'(buzz_out), 1);

    // Divided mode at each ratio with the gate open.
    for (int r = 0; r < 4; r++) begin
      exp_half = 0;
      cur_req = "R7";
      wr(4'(4'b1100 | r));
      cyc(1);
      check(buzz_out === 1'b0, "R7", int'(buzz_out), 0);
      cyc(3);
      check(buzz_out === 1'b0, "R7", int'(buzz_out), 0);
      exp_half = 1 << r;
      cur_req = "R4";
      cyc(70);
    end

    // Toggle strobes during divided mode must not move the level.
    cur_req = "R9";
    strobe(0); strobe(1);

    // Gate closed and reopened at every phase offset of ratio 8.
    exp_half = 0;
    wr(4'b1110); cyc(1);
    exp_half = 4;
    cur_req = "R5";
    for (int k = 0; k < 8; k++) begin
      cyc(k);
      wr(4'b0110);
      cyc(12);
      check(buzz_out === 1'b0, "R5", int'(buzz_out), 0);
      cyc(k + 1);
      wr(4'b1110);
      cyc(9);
    end

    // Back to toggle mode: level from before is restored.
    exp_half = 0;
    cur_req = "R9";
    wr(4'b0010); cyc(1);
    check(buzz_out === 1'b1, "R9", int'(buzz_out), 1);
    strobe(1); cyc(1);
    check(buzz_out === 1'b0, "R3", int'(buzz_out), 0);
    cyc(4);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule